// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two buses, called A and B. Each direction has three things of its own:

- a storage register that samples its source bus,
- a select that picks either live data or the stored word,
- an output enable.

The A-to-B enable is active high and the B-to-A enable is active low. By combining them, software or a controller can run the block in several modes: both buses isolated, words captured, live data passed through, stored words replayed, or stored words exchanged between the buses.

Each bus is modelled for synthesis as three signals: an input word, an output word and a drive flag. When the block drives a bus, the value on that bus terminal is the driven word. A register that captures that bus therefore takes the driven word. This lets one bus value be loaded into both registers in a single cycle.

The two capture clocks are modelled as capture strobes sampled on one system clock. Reset is synchronous and active low. The live path always reads the external input word of the opposite bus, so enabling both live directions cannot form a combinational loop.

Top module: `xcvr_registered_bus`

## Requirements
- R1: A low `rst_n` at a clock edge clears both storage registers to zero; afterwards a stored-mode output shows zero.
- R2: At a clock edge where `cap_a` (or `cap_b`) is high, the A-side (or B-side) register loads the current bus A (or B) terminal value, whatever the selects and enables are; with the strobe low the register keeps its value.
- R3: A select at 0 (live) makes the driven word equal the opposite bus input word in the same cycle, with no register delay.
- R4: A select at 1 (stored) makes the driven word equal the register contents; a newly captured word appears on the output right after its capture edge.
- R5: `b_drive` is high exactly when `en_ab` is 1 (active-high enable).
- R6: `a_drive` is high exactly when `en_ba_n` is 0 (active-low enable).
- R7: An output word whose drive flag is low reads as all zeros.
- R8: With `en_ab`=0 and `en_ba_n`=1, neither bus is driven, and captures still load both registers.
- R9: With both directions enabled and both selects at 1, bus B carries the A-side register and bus A carries the B-side register in the same cycle.
- R10: The bus terminal value used for capture is the driven word when the block drives that bus and the external input word otherwise; this loads a single bus value into both registers.
- R11: With both directions enabled and both selects at 0, `a_out` equals `b_in` and `b_out` equals `a_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | DATA_W | Word present on bus A from outside |
| a_out | output | DATA_W | Word the block drives onto bus A |
| a_drive | output | 1 | High when the block drives bus A |
| b_in | input | DATA_W | Word present on bus B from outside |
| b_out | output | DATA_W | Word the block drives onto bus B |
| b_drive | output | 1 | High when the block drives bus B |
| cap_a | input | 1 | Capture strobe for the A-side register |
| cap_b | input | 1 | Capture strobe for the B-side register |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | A-to-B output enable, active high |
| en_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
The assertions check the following on every cycle:

- register capture and hold against the strobes,
- the clearing on reset,
- that isolation drives neither bus,
- that a stored path shows the captured terminal value right after the edge,
- that both live directions cross-connect the input words.

Only the bench scenarios can show two things. The first is a bus value landing in both registers through the driven terminal. The second is a simultaneous exchange of stored words. The bench also covers the live path settling before any clock edge and a sweep of all sixteen control combinations against an independent model.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes two transfer directions, indexed A-to-B then B-to-A.
package xcvr_pkg;
    localparam int DIR_AB   = 0;
    localparam int DIR_BA   = 1;
    localparam int NUM_DIRS = 2;

    // Source choice for one direction: live input word or stored word.
    typedef enum logic {
        SEL_LIVE   = 1'b0,
        SEL_STORED = 1'b1
    } path_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
// One direction's storage register: loads its word on a clock edge when
// the capture strobe is high, otherwise keeps it. Assumes a synchronous
// active-low reset that clears the word.
module xcvr_store_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    // Capture or hold the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (cap_i) begin
            q_o <= d_i;
        end
    end

    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> q_o == $past(d_i));

    // R2
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(q_o));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q_o == '0);
endmodule

// File: rtl/xcvr_path_sel.sv
// One direction's output path: picks the live or the stored word and
// gates it with the output enable. ENABLE_LOW picks the enable polarity.
// An undriven output word is held at zero. Purely combinational.
module xcvr_path_sel
    import xcvr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit ENABLE_LOW = 1'b0
) (
    input  logic [DATA_W-1:0] live_i,
    input  logic [DATA_W-1:0] stored_i,
    input  path_sel_e         sel_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] out_o,
    output logic              drive_o
);
    logic [DATA_W-1:0] picked;

    // Resolve the enable polarity chosen for this direction.
    generate
        if (ENABLE_LOW) begin : g_en_low
            assign drive_o = ~en_i;
        end else begin : g_en_high
            assign drive_o = en_i;
        end
    endgenerate

    // Choose the word source, then gate it with the enable.
    always_comb begin
        picked = (sel_i == SEL_STORED) ? stored_i : live_i;
        out_o  = drive_o ? picked : '0;
    end
endmodule

// File: rtl/xcvr_registered_bus.sv
// Registered bidirectional bus transceiver between buses A and B.
// Each direction has a storage register, a live/stored select and an
// output enable: active high for A-to-B, active low for B-to-A.
// Each bus is split into an input word, an output word and a drive flag.
// A register captures its bus terminal value: the driven word when the
// block drives that bus, else the external input. Live paths read the
// external input only, so no combinational loop can form.
module xcvr_registered_bus
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic              en_ab,
    input  logic              en_ba_n
);
    // Per-direction vectors, indexed by the source bus of each direction.
    logic [DATA_W-1:0] src_in   [NUM_DIRS];
    logic [DATA_W-1:0] stored_q [NUM_DIRS];
    logic [DATA_W-1:0] dir_out  [NUM_DIRS];
    logic [DATA_W-1:0] bus_term [NUM_DIRS];
    logic              dir_drv  [NUM_DIRS];
    logic              cap_v    [NUM_DIRS];
    logic              en_v     [NUM_DIRS];
    path_sel_e         sel_v    [NUM_DIRS];

    // Gather the port controls into direction order.
    always_comb begin
        src_in[DIR_AB] = a_in;
        src_in[DIR_BA] = b_in;
        cap_v[DIR_AB]  = cap_a;
        cap_v[DIR_BA]  = cap_b;
        en_v[DIR_AB]   = en_ab;
        en_v[DIR_BA]   = en_ba_n;
        sel_v[DIR_AB]  = path_sel_e'(sel_ab);
        sel_v[DIR_BA]  = path_sel_e'(sel_ba);
    end

    // One register and one output path per direction.
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        localparam int OPP = NUM_DIRS - 1 - d;

        xcvr_store_reg #(.DATA_W(DATA_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (cap_v[d]),
            .d_i   (bus_term[d]),
            .q_o   (stored_q[d])
        );

        xcvr_path_sel #(
            .DATA_W     (DATA_W),
            .ENABLE_LOW (d == DIR_BA)
        ) u_path (
            .live_i   (src_in[d]),
            .stored_i (stored_q[d]),
            .sel_i    (sel_v[d]),
            .en_i     (en_v[d]),
            .out_o    (dir_out[d]),
            .drive_o  (dir_drv[d])
        );

        // The terminal of bus d carries the opposite direction's word when it is driven.
        assign bus_term[d] = dir_drv[OPP] ? dir_out[OPP] : src_in[d];
    end

    // Map the direction outputs onto the bus ports.
    always_comb begin
        b_out   = dir_out[DIR_AB];
        b_drive = dir_drv[DIR_AB];
        a_out   = dir_out[DIR_BA];
        a_drive = dir_drv[DIR_BA];
    end

    // R8
    isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ab && en_ba_n) |-> (!a_drive && !b_drive));

    // R4
    stored_ab_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && sel_ab && $past(cap_a) && $past(rst_n)) |-> b_out == $past(bus_term[DIR_AB]));

    // R4
    stored_ba_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ba_n && sel_ba && $past(cap_b) && $past(rst_n)) |-> a_out == $past(bus_term[DIR_BA]));

    // R11
    live_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && !sel_ab && !en_ba_n && !sel_ba) |-> (a_out == b_in && b_out == a_in));
endmodule

// File: tb/tb_xcvr_registered_bus.sv
// Scoreboard bench: the driver task models each step, checks the
// pre-edge outputs and queues the post-edge expectation; the monitor
// pops and compares after each rising edge.
module tb_xcvr_registered_bus;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a_out;
        logic         a_drv;
        logic [W-1:0] b_out;
        logic         b_drv;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive;
    logic cap_a = 0, cap_b = 0, sel_ab = 0, sel_ba = 0, en_ab = 0, en_ba_n = 1;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    exp_t sb[$];
    logic [W-1:0] ma = '0, mb = '0;

    always #5 clk = ~clk;

    xcvr_registered_bus #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .cap_a(cap_a), .cap_b(cap_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n)
    );

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(exp_t e);
        chk(e.tag, "a_out", a_out, e.a_out);
        chk(e.tag, "a_drive", {7'd0, a_drive}, {7'd0, e.a_drv});
        chk(e.tag, "b_out", b_out, e.b_out);
        chk(e.tag, "b_drive", {7'd0, b_drive}, {7'd0, e.b_drv});
    endtask

    // Expected outputs from the requirements (R3..R7) for given registers.
    function automatic exp_t model(logic [W-1:0] ra, logic [W-1:0] rb, string tag);
        exp_t e;
        e.b_drv = en_ab;
        e.a_drv = !en_ba_n;
        e.b_out = en_ab ? (sel_ab ? ra : a_in) : '0;
        e.a_out = !en_ba_n ? (sel_ba ? rb : b_in) : '0;
        e.tag   = tag;
        return e;
    endfunction

    // Drive one step, check the pre-edge outputs, queue the post-edge ones.
    task automatic step(bit ca, bit cb, bit sab, bit sba, bit eab, bit eban,
                        logic [W-1:0] a, logic [W-1:0] b, string tag);
        exp_t pre;
        logic [W-1:0] term_a, term_b;
        @(negedge clk);
        cap_a = ca; cap_b = cb; sel_ab = sab; sel_ba = sba;
        en_ab = eab; en_ba_n = eban; a_in = a; b_in = b;
        #1;
        pre = model(ma, mb, tag);
        compare(pre);
        // R10: terminal value is the driven word when the block drives that bus
        term_a = pre.a_drv ? pre.a_out : a;
        term_b = pre.b_drv ? pre.b_out : b;
        if (ca) ma = term_a;
        if (cb) mb = term_b;
        sb.push_back(model(ma, mb, tag));
    endtask

    // Monitor: after each rising edge compare the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog req=all actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: both stored paths read zero after reset
        step(0, 0, 1, 1, 1, 0, 8'hAA, 8'h55, "R1");
        // R8: isolation, nothing driven (R7 zero words), captures still load
        step(1, 1, 0, 0, 0, 1, 8'h3C, 8'hC3, "R8");
        // R9: stored exchange
        step(0, 0, 1, 1, 1, 0, 8'h00, 8'hFF, "R9");
        // R2: no strobe, registers hold
        step(0, 0, 1, 1, 1, 0, 8'h81, 8'h18, "R2");
        // R3 / R5 / R6: live A-to-B only
        step(0, 0, 0, 0, 1, 1, 8'h5A, 8'h11, "R3");
        // R3 / R6: live B-to-A only
        step(0, 0, 0, 0, 0, 0, 8'h22, 8'hA5, "R6");
        // R4: stored A-to-B, new word shown after its capture edge
        step(1, 0, 1, 0, 1, 1, 8'h77, 8'h00, "R4");
        step(0, 0, 1, 0, 1, 1, 8'h01, 8'h00, "R4");
        // R10: store A in both registers via the driven B terminal
        step(1, 1, 0, 0, 1, 1, 8'hE1, 8'h0F, "R10");
        step(0, 0, 1, 1, 1, 0, 8'h00, 8'h00, "R10");
        // R10: store B in both registers via the driven A terminal
        step(1, 1, 0, 0, 0, 0, 8'h11, 8'h9D, "R10");
        step(0, 0, 1, 1, 1, 0, 8'h00, 8'h00, "R10");
        // R10: stored A word driven onto B and captured into B register
        step(0, 1, 1, 0, 1, 1, 8'h44, 8'h66, "R10");
        step(0, 0, 1, 1, 1, 0, 8'h00, 8'h00, "R10");
        // R11: both live, reinforcing and cross-connected patterns
        step(0, 0, 0, 0, 1, 0, 8'h66, 8'h66, "R11");
        step(0, 0, 0, 0, 1, 0, 8'h12, 8'h34, "R11");
        step(1, 1, 0, 0, 1, 0, 8'hC0, 8'h0C, "R11");
        step(0, 0, 1, 1, 1, 0, 8'h00, 8'h00, "R11");

        // R2: sweep every control combination with strobes
        for (int i = 0; i < 16; i++) begin
            step(i[0], i[1] ^ i[3], i[1], i[2], i[3], i[0] ^ i[2],
                 W'(i * 37 + 5), W'(i * 91 + 3), "R2");
        end

        // R1: reset mid-run clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        ma = '0;
        mb = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 1, 1, 1, 0, 8'hF0, 8'h0F, "R1");

        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule